// File: doc/BRIEF.md
# Bridge Exclusive-Access Lock Controller

This block is the state machine that manages exclusive (locked) access sequences in a two-bus transaction bridge. It watches the LOCK# and FRAME# levels on the initiator bus, together with event strobes from the forwarding engine. These strobes say that a locked transaction has started, whether it is posted or delayed, and how it ended on the target side. From them the block drives LOCK# on the target bus and gates the forwarding of unlocked traffic. It also returns a stored abort to an initiator that repeats the transaction, keeps sticky abort status bits, and pulses SERR# when the configuration allows it.

The block works on event strobes, not on pin-level handshakes. The termination code on `xact_term` uses these values: 0 = completed, 1 = target retry, 2 = target abort, 3 = master abort. The states are idle, first transaction in flight, lock held, abort waiting for the initiator to repeat, and a one-cycle release. While the lock is held, the engine marks each further locked transaction with `xact_start` and ends it with `xact_done`.

Top module: `bridge_lock_ctrl`

## Requirements
- R1: After reset, `tgt_lock_n`=1, `fwd_en`=1, `serr_n`=1, `abort_ret`=00 and `stat_abort`=00.
- R2: In idle, `xact_start` drives `tgt_lock_n` low and `fwd_en` low from the next cycle. Later locked transactions keep `tgt_lock_n` low.
- R3: A retry (code 1) on the first transaction of a sequence drives `tgt_lock_n` high the next cycle. `fwd_en` returns high one cycle after that.
- R4: A retry on any later transaction of a sequence leaves `tgt_lock_n` low.
- R5: While the lock is held and no transaction is in flight, sampling both `init_lock_n` and `init_frame_n` high drives `tgt_lock_n` high the next cycle. If `init_frame_n` is low, the lock stays held.
- R6: A completed posted transaction with `init_lock_n` high at its `xact_done` drives `tgt_lock_n` high the next cycle.
- R7: An abort on a delayed transaction drops `tgt_lock_n` and holds `abort_ret`. The value is 10 for a target abort and 11 for a master abort. `fwd_en` stays low until `repeat_hit`. In the cycle after `repeat_hit`, `abort_ret` is 00 and `fwd_en` is 1.
- R8: An abort on a posted transaction drives `serr_n` low for exactly the one cycle after `xact_done`. This happens only if `serr_en` is 1, and, for a master abort, `mabort_mode` is also 1.
- R9: `stat_abort[0]` records target aborts and `stat_abort[1]` records master aborts of locked transactions. Each bit is sticky until a 1 is written to it on `stat_clr`; a new abort wins over a clear in the same cycle.
- R10: `fwd_en` rises only after `tgt_lock_n` was already high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| init_lock_n | input | 1 | Initiator-bus LOCK# level |
| init_frame_n | input | 1 | Initiator-bus FRAME# level |
| xact_start | input | 1 | Locked transaction forwarded to the target |
| xact_posted | input | 1 | 1 = posted write, 0 = delayed; valid with `xact_start` |
| xact_done | input | 1 | Target-side termination strobe |
| xact_term | input | 2 | Termination code, valid with `xact_done` |
| repeat_hit | input | 1 | Initiator repeated the aborted delayed transaction |
| serr_en | input | 1 | SERR# enable command bit |
| mabort_mode | input | 1 | Master-abort-mode control bit |
| stat_clr | input | 2 | Write-1-to-clear for `stat_abort` |
| tgt_lock_n | output | 1 | Target-bus LOCK# |
| fwd_en | output | 1 | Unlocked forwarding allowed in both directions |
| abort_ret | output | 2 | Abort returned to the repeating initiator |
| stat_abort | output | 2 | Sticky abort status bits |
| serr_n | output | 1 | SERR# pulse on the initiator bus |

## Verification
The assertions assume two things about the forwarding engine. First, it sends `xact_done` only for a transaction it has started. Second, it does not raise `xact_start` while the initiator is already signalling release. The bench keeps within these limits: every random trial is one start/done pair, optionally followed by a second pair, and release or `repeat_hit` comes only after the last done. The random trials cover all termination codes, both transaction kinds and every SERR# configuration, on both the first and a later transaction.

// File: rtl/bridge_lock_ctrl.sv
module bridge_lock_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_lock_n,
  input  logic       init_frame_n,
  input  logic       xact_start,
  input  logic       xact_posted,
  input  logic       xact_done,
  input  logic [1:0] xact_term,
  input  logic       repeat_hit,
  input  logic       serr_en,
  input  logic       mabort_mode,
  input  logic [1:0] stat_clr,
  output logic       tgt_lock_n,
  output logic       fwd_en,
  output logic [1:0] abort_ret,
  output logic [1:0] stat_abort,
  output logic       serr_n
);

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_HELD, S_ABT, S_REL} st_t;

  st_t  st, st_nx;
  logic posted_q, busy_q, mab_q;

  wire in_flight = (st == S_PEND) || (st == S_HELD && busy_q);
  wire ev_done   = xact_done && in_flight;
  wire ev_ok     = ev_done && xact_term == 2'd0;
  wire ev_retry  = ev_done && xact_term == 2'd1;
  wire ev_abort  = ev_done && xact_term[1];
  wire is_mab    = xact_term == 2'd3;
  wire can_start = (st == S_IDLE) || (st == S_HELD && !busy_q);
  wire released  = init_lock_n && init_frame_n;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (xact_start) st_nx = S_PEND;
      S_PEND, S_HELD: begin
        if (ev_retry)
          st_nx = (st == S_PEND) ? S_REL : S_HELD;
        else if (ev_abort)
          st_nx = posted_q ? S_REL : S_ABT;
        else if (ev_ok)
          st_nx = (posted_q && init_lock_n) ? S_REL : S_HELD;
        else if (st == S_HELD && !busy_q && !xact_start && released)
          st_nx = S_REL;
      end
      S_ABT:   if (repeat_hit) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      posted_q   <= 1'b0;
      busy_q     <= 1'b0;
      mab_q      <= 1'b0;
      serr_n     <= 1'b1;
      stat_abort <= 2'b00;
    end else begin
      st     <= st_nx;
      busy_q <= (st == S_HELD) && (st_nx == S_HELD) &&
                (busy_q ? !xact_done : xact_start);
      if (xact_start && can_start) posted_q <= xact_posted;
      if (ev_abort) mab_q <= is_mab;
      serr_n <= !(ev_abort && posted_q && serr_en && (!is_mab || mabort_mode));
      stat_abort[0] <= (stat_abort[0] & ~stat_clr[0]) | (ev_abort & ~is_mab);
      stat_abort[1] <= (stat_abort[1] & ~stat_clr[1]) | (ev_abort & is_mab);
    end
  end

  assign tgt_lock_n = !(st == S_PEND || st == S_HELD);
  assign fwd_en     = (st == S_IDLE);
  assign abort_ret  = (st == S_ABT) ? {1'b1, mab_q} : 2'b00;

endmodule

module bridge_lock_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       busy_q,
  input logic       init_lock_n,
  input logic       init_frame_n,
  input logic       xact_done,
  input logic [1:0] xact_term,
  input logic       repeat_hit,
  input logic       serr_en,
  input logic       mabort_mode,
  input logic       tgt_lock_n,
  input logic       fwd_en,
  input logic [1:0] abort_ret,
  input logic       serr_n
);
  localparam logic [2:0] C_HELD = 3'd2;
  localparam logic [2:0] C_ABT  = 3'd3;

  a_r10_fwd_after_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_en) |-> $past(tgt_lock_n));

  a_r4_retry_later_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_HELD && busy_q && xact_done && xact_term == 2'd1) |=> !tgt_lock_n);

  a_r5_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_HELD && !busy_q && !(init_lock_n && init_frame_n)) |=> !tgt_lock_n);

  a_r7_abort_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ABT && !repeat_hit) |=> (abort_ret[1] && abort_ret == $past(abort_ret) && !fwd_en));

  a_r8_serr_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |=> serr_n);

  a_r8_serr_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(serr_n) |-> $past(serr_en && xact_done && xact_term[1]));

  a_r8_mab_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(serr_n) && $past(xact_term == 2'd3)) |-> $past(mabort_mode));
endmodule

bind bridge_lock_ctrl bridge_lock_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .busy_q(busy_q),
  .init_lock_n(init_lock_n), .init_frame_n(init_frame_n),
  .xact_done(xact_done), .xact_term(xact_term), .repeat_hit(repeat_hit),
  .serr_en(serr_en), .mabort_mode(mabort_mode), .tgt_lock_n(tgt_lock_n),
  .fwd_en(fwd_en), .abort_ret(abort_ret), .serr_n(serr_n)
);

// File: tb/test_bridge_lock_ctrl.sv
module test_bridge_lock_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic init_lock_n = 1'b1, init_frame_n = 1'b1;
  logic xact_start = 1'b0, xact_posted = 1'b0, xact_done = 1'b0;
  logic [1:0] xact_term = 2'd0;
  logic repeat_hit = 1'b0, serr_en = 1'b0, mabort_mode = 1'b0;
  logic [1:0] stat_clr = 2'b00;
  logic tgt_lock_n, fwd_en, serr_n;
  logic [1:0] abort_ret, stat_abort;
  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  bridge_lock_ctrl i_bridge_lock_ctrl (.*);

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic start_x(bit posted);
    xact_start = 1; xact_posted = posted; cyc(); xact_start = 0;
  endtask

  task automatic done_x(logic [1:0] code);
    xact_done = 1; xact_term = code; cyc(); xact_done = 0;
  endtask

  task automatic cleanup();
    init_lock_n = 1; init_frame_n = 1; repeat_hit = 1; stat_clr = 2'b11;
    cyc(); repeat_hit = 0; stat_clr = 2'b00;
    cyc(); cyc();
  endtask

  function automatic bit exp_serr_low(bit posted, logic [1:0] code, bit en, bit mm);
    return posted && code[1] && en && (code == 2'd2 || mm);
  endfunction

  function automatic bit exp_lock_n(bit first, bit posted, logic [1:0] code);
    if (code == 2'd1) return first;
    if (code[1]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [1:0] exp_ret(bit posted, logic [1:0] code);
    return (code[1] && !posted) ? code : 2'b00;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    cyc(); cyc(); rst_n = 1; cyc();
    chk("R1 lock", tgt_lock_n, 1); chk("R1 fwd", fwd_en, 1);
    chk("R1 serr", serr_n, 1); chk("R1 ret", abort_ret, 0); chk("R1 stat", stat_abort, 0);

    // R2 / R3: retry on first transaction releases
    init_lock_n = 0; init_frame_n = 0;
    start_x(0);
    chk("R2 lock asserted", tgt_lock_n, 0); chk("R2 fwd gated", fwd_en, 0);
    done_x(2'd1);
    chk("R3 retry first drops lock", tgt_lock_n, 1); chk("R10 fwd still off", fwd_en, 0);
    cyc(); chk("R3 fwd resumes", fwd_en, 1);
    cleanup();

    // R4 / R5: retry on later transaction, delayed release
    init_lock_n = 0; init_frame_n = 0;
    start_x(0); done_x(2'd0); chk("R2 held", tgt_lock_n, 0);
    start_x(0); chk("R2 later locked", tgt_lock_n, 0);
    done_x(2'd1); chk("R4 retry later keeps lock", tgt_lock_n, 0);
    start_x(0); done_x(2'd0);
    init_lock_n = 1; cyc(); cyc();
    chk("R5 frame low keeps lock", tgt_lock_n, 0);
    init_frame_n = 1; cyc();
    chk("R5 release", tgt_lock_n, 1); chk("R10 fwd lag", fwd_en, 0);
    cyc(); chk("R5 fwd resumes", fwd_en, 1);

    // R6: posted last transaction
    init_lock_n = 0; init_frame_n = 0;
    start_x(1); done_x(2'd0); chk("R6 held after posted", tgt_lock_n, 0);
    start_x(1); init_lock_n = 1; done_x(2'd0);
    chk("R6 release at write end", tgt_lock_n, 1);
    cyc(); chk("R6 fwd resumes", fwd_en, 1);
    cleanup();

    // R7 / R9: delayed aborts
    init_lock_n = 0; init_frame_n = 0;
    start_x(0); done_x(2'd0); start_x(0); done_x(2'd2);
    chk("R7 target abort ret", abort_ret, 2'b10); chk("R7 lock drop", tgt_lock_n, 1);
    chk("R9 tabort stat", stat_abort, 2'b01);
    cyc(); cyc(); chk("R7 ret held", abort_ret, 2'b10); chk("R7 fwd held off", fwd_en, 0);
    repeat_hit = 1; cyc(); repeat_hit = 0;
    chk("R7 ret cleared", abort_ret, 0); chk("R7 fwd resumes", fwd_en, 1);
    cyc(); chk("R9 sticky", stat_abort, 2'b01);
    stat_clr = 2'b01; cyc(); stat_clr = 0; chk("R9 w1c", stat_abort, 0);
    start_x(0); stat_clr = 2'b10; done_x(2'd3); stat_clr = 0;
    chk("R7 master abort first", abort_ret, 2'b11); chk("R9 set wins", stat_abort, 2'b10);
    cleanup();

    // R8: every SERR# enable combination for both abort types
    for (int i = 0; i < 8; i++) begin
      logic [1:0] code;
      serr_en = i[0]; mabort_mode = i[1]; code = i[2] ? 2'd3 : 2'd2;
      init_lock_n = 0; init_frame_n = 0;
      start_x(1); done_x(2'd0); start_x(1); done_x(code);
      chk("R8 serr", serr_n, !exp_serr_low(1, code, serr_en, mabort_mode));
      chk("R9 stat", stat_abort, code == 2'd3 ? 2'b10 : 2'b01);
      cyc(); chk("R8 one clk", serr_n, 1);
      cleanup();
    end

    // random trials
    for (int t = 0; t < 60; t++) begin
      bit first, p;
      logic [1:0] code;
      first = $urandom_range(0, 1); p = $urandom_range(0, 1);
      code = 2'($urandom_range(0, 3));
      serr_en = $urandom_range(0, 1); mabort_mode = $urandom_range(0, 1);
      init_lock_n = 0; init_frame_n = 0;
      if (!first) begin start_x($urandom_range(0, 1)); done_x(2'd0); end
      start_x(p); done_x(code);
      chk(first ? "R3 rnd lock first" : "R4 rnd lock later", tgt_lock_n, exp_lock_n(first, p, code));
      chk("R7 rnd ret", abort_ret, exp_ret(p, code));
      chk("R8 rnd serr", serr_n, !exp_serr_low(p, code, serr_en, mabort_mode));
      cleanup();
      chk("R10 rnd idle", {fwd_en, tgt_lock_n}, 2'b11);
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule